// File: doc/BRIEF.md
# Timer Channel Compare Output Unit

This block is one compare channel that sits beside a shared timer counter. Each clock it receives the counter value, the reload value, a flag that is set while the counter counts down, and a flag that selects up/down counting instead of modulo counting. It compares the counter against its own compare value. From that result it drives one channel output pin and a one-cycle interrupt request.

Software programs the channel through a byte-wide write port. Address 0 holds a control byte. The addresses after it hold the compare value, one byte each. The control byte selects the operating mode: one-shot pulse, continuous toggle, or pulse-width modulation. It also holds the output polarity, the enable and interrupt enable bits, and whether new compare values apply at once or wait for the end of the timer period.

The output logic is a small state machine with three states:
- `ST_OFF`: the channel is disabled.
- `ST_RUN`: the channel is enabled and waiting for a compare match.
- `ST_PULSE`: the one clock of a one-shot pulse.

The transitions are:
- `ST_OFF` to `ST_RUN` on a control write that sets the enable bit.
- `ST_RUN` to `ST_PULSE` on a one-shot match.
- `ST_PULSE` to `ST_RUN` after one clock.
- Any enabled state to `ST_OFF` on a control write that clears the enable bit.

Top module: `tmr_cmp_channel`

## Requirements
- R1: After reset, every control bit and the compare value are 0, the output is low and the interrupt request is low.
- R2: While the enable bit is 0, the channel output equals the polarity bit in every cycle, including the cycle right after a polarity change.
- R3: On the clock edge of a control write that sets the enable bit on a disabled channel, the output takes the polarity bit written in that same byte. Any compare match in that cycle is ignored.
- R4: In one-shot mode (mode code 000) with the channel enabled, a counter value equal to the compare value inverts the output at the next clock edge. The output reverts to its former level one clock later.
- R5: In continuous mode (code 001) with the channel enabled, each cycle where the counter equals the compare value inverts the output at the next edge. The new level is held until the next match.
- R6: In PWM mode (code 010) with the channel enabled, a match sets the output to its active level at the next edge. The active level is high when the polarity bit is 0 and low when it is 1.
- R7: In PWM mode with modulo counting (up/down flag 0), a counter value equal to the reload value returns the output to its inactive level at the next edge. If the counter equals both the compare and the reload value, the match wins.
- R8: In PWM mode with up/down counting (up/down flag 1), a match while the down flag is 0 sets the active level. A match while the down flag is 1 sets the inactive level.
- R9: In the cycle after each match, the interrupt request is high for one cycle, provided the channel was enabled and its interrupt enable bit was set. In all other cycles it stays low.
- R10: With the update enable bit at 0, a written compare byte is used for matching from the next cycle on.
- R11: With the update enable bit at 1, a written compare byte is held in a buffer. The byte moves into use at the next end-of-period event, which is the counter equal to the reload value in modulo counting and the counter equal to 0 with the down flag set in up/down counting. The buffered bytes are copied in the state they had before that edge.
- R12: Mode codes 011 through 111 leave an enabled output at its current level.
- R13: The control byte is at address 0: bit 7 enable, bit 6 polarity, bit 5 interrupt enable, bit 4 update enable, bit 3 ignored, bits 2:0 mode. Compare bytes follow at addresses 1 upward, least significant byte first. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Shared timer counter value |
| reload_val | input | CNT_W | Shared timer reload value |
| cnt_down | input | 1 | High while the counter counts down |
| updown_mode | input | 1 | 1 = up/down counting, 0 = modulo counting |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | ADDR_W | Register address (0 control, 1.. compare bytes) |
| wr_data | input | 8 | Write data byte |
| ch_out | output | 1 | Channel output pin |
| ch_irq | output | 1 | One-cycle channel interrupt request |

## Verification
The bench builds the block with its default 16-bit counter width, which gives two compare bytes and one spare address. This lets it show that the high byte matters: a compare value of 0x0107 never matches while the counter stays at or below its reload of 20. It also lets it show that writes to the spare address are ignored. Keeping the reload small lets the bench cover many full periods in each mode, in both counting schemes, with every compare byte buffered or immediate.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam logic [2:0] MODE_ONESHOT = 3'b000;
    localparam logic [2:0] MODE_CONT    = 3'b001;
    localparam logic [2:0] MODE_PWM     = 3'b010;

    localparam int CTRL_EN_BIT  = 7;
    localparam int CTRL_POL_BIT = 6;
    localparam int CTRL_IE_BIT  = 5;
    localparam int CTRL_UE_BIT  = 4;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_PULSE = 2'd2
    } chan_state_t;

endpackage

// File: rtl/tcc_regs.sv
module tcc_regs #(
    parameter int CNT_W  = 16,
    parameter int NBYTES = CNT_W / 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              period_evt,
    output logic              en_q,
    output logic              pol_q,
    output logic              ie_q,
    output logic [2:0]        mode_q,
    output logic [CNT_W-1:0]  cmp_active
);
    import tcc_pkg::*;

    logic             ue_q;
    logic [CNT_W-1:0] cmp_shadow;
    logic             ctrl_hit;

    assign ctrl_hit = wr_en && (wr_addr == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pol_q  <= 1'b0;
            ie_q   <= 1'b0;
            ue_q   <= 1'b0;
            mode_q <= 3'b000;
        end else if (ctrl_hit) begin
            en_q   <= wr_data[CTRL_EN_BIT];
            pol_q  <= wr_data[CTRL_POL_BIT];
            ie_q   <= wr_data[CTRL_IE_BIT];
            ue_q   <= wr_data[CTRL_UE_BIT];
            mode_q <= wr_data[2:0];
        end
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_cmp_byte
        logic byte_hit;
        assign byte_hit = wr_en && (wr_addr == ADDR_W'(b + 1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_shadow[b*8 +: 8] <= 8'h00;
                cmp_active[b*8 +: 8] <= 8'h00;
            end else begin
                if (byte_hit)
                    cmp_shadow[b*8 +: 8] <= wr_data;
                if (byte_hit && !ue_q)
                    cmp_active[b*8 +: 8] <= wr_data;
                else if (period_evt)
                    cmp_active[b*8 +: 8] <= cmp_shadow[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/tcc_match.sv
module tcc_match #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] cmp_active,
    input  logic             cnt_down,
    input  logic             updown_mode,
    output logic             match,
    output logic             period_evt,
    output logic             pwm_set,
    output logic             pwm_clr
);
    logic at_reload;
    logic at_bottom;

    assign match     = (cnt_val == cmp_active);
    assign at_reload = (cnt_val == reload_val);
    assign at_bottom = (cnt_val == '0) && cnt_down;

    always_comb begin
        if (updown_mode) begin
            period_evt = at_bottom;
            pwm_set    = match && !cnt_down;
            pwm_clr    = match && cnt_down;
        end else begin
            period_evt = at_reload;
            pwm_set    = match;
            pwm_clr    = at_reload && !match;
        end
    end

endmodule

// File: rtl/tcc_outfsm.sv
module tcc_outfsm (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic                 new_en,
    input  logic                 new_pol,
    input  logic                 en_q,
    input  logic                 pol_q,
    input  logic                 ie_q,
    input  logic [2:0]           mode_q,
    input  logic                 match,
    input  logic                 pwm_set,
    input  logic                 pwm_clr,
    output tcc_pkg::chan_state_t state_q,
    output logic                 ch_out,
    output logic                 ch_irq
);
    import tcc_pkg::*;

    chan_state_t state_d;
    logic        en_next;
    logic        out_q;
    logic        irq_q;

    assign en_next = ctrl_wr ? new_en : en_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (ctrl_wr && new_en) state_d = ST_RUN;
            ST_RUN: begin
                if (!en_next)
                    state_d = ST_OFF;
                else if (mode_q == MODE_ONESHOT && match)
                    state_d = ST_PULSE;
            end
            ST_PULSE: state_d = en_next ? ST_RUN : ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= (state_q != ST_OFF) && ie_q && match;
            unique case (state_q)
                ST_OFF:   out_q <= (ctrl_wr && new_en) ? new_pol : pol_q;
                ST_RUN: begin
                    unique case (mode_q)
                        MODE_ONESHOT, MODE_CONT: if (match) out_q <= !out_q;
                        MODE_PWM: begin
                            if (pwm_set)      out_q <= !pol_q;
                            else if (pwm_clr) out_q <= pol_q;
                        end
                        default: out_q <= out_q;
                    endcase
                end
                ST_PULSE: out_q <= !out_q;
                default:  out_q <= pol_q;
            endcase
        end
    end

    assign ch_out = (state_q == ST_OFF) ? pol_q : out_q;
    assign ch_irq = irq_q;

endmodule

// File: rtl/tmr_cmp_channel.sv
module tmr_cmp_channel #(
    parameter int CNT_W  = 16,
    parameter int NBYTES = CNT_W / 8,
    parameter int ADDR_W = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              cnt_down,
    input  logic              updown_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              ch_out,
    output logic              ch_irq
);
    import tcc_pkg::*;

    logic             en_q;
    logic             pol_q;
    logic             ie_q;
    logic [2:0]       mode_q;
    logic [CNT_W-1:0] cmp_active;
    logic             match;
    logic             period_evt;
    logic             pwm_set;
    logic             pwm_clr;
    logic             ctrl_wr;
    chan_state_t      state_q;

    assign ctrl_wr = wr_en && (wr_addr == '0);

    tcc_regs #(.CNT_W(CNT_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .period_evt (period_evt),
        .en_q       (en_q),
        .pol_q      (pol_q),
        .ie_q       (ie_q),
        .mode_q     (mode_q),
        .cmp_active (cmp_active)
    );

    tcc_match #(.CNT_W(CNT_W)) i_match (
        .cnt_val     (cnt_val),
        .reload_val  (reload_val),
        .cmp_active  (cmp_active),
        .cnt_down    (cnt_down),
        .updown_mode (updown_mode),
        .match       (match),
        .period_evt  (period_evt),
        .pwm_set     (pwm_set),
        .pwm_clr     (pwm_clr)
    );

    tcc_outfsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .new_en  (wr_data[CTRL_EN_BIT]),
        .new_pol (wr_data[CTRL_POL_BIT]),
        .en_q    (en_q),
        .pol_q   (pol_q),
        .ie_q    (ie_q),
        .mode_q  (mode_q),
        .match   (match),
        .pwm_set (pwm_set),
        .pwm_clr (pwm_clr),
        .state_q (state_q),
        .ch_out  (ch_out),
        .ch_irq  (ch_irq)
    );

endmodule

// File: rtl/tcc_chk.sv
module tcc_chk (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic                 en_q,
    input logic                 pol_q,
    input logic                 ie_q,
    input logic [2:0]           mode_q,
    input logic                 match,
    input logic                 cnt_down,
    input logic                 updown_mode,
    input tcc_pkg::chan_state_t state_q,
    input logic                 ch_out,
    input logic                 ch_irq
);
    import tcc_pkg::*;

    // R2: a disabled channel drives its polarity bit
    a_r2_disabled_pol: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (ch_out == pol_q));

    // R4: the one-shot pulse lasts one clock, then reverts
    a_r4_pulse_reverts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !wr_en) |=> (ch_out != $past(ch_out)));

    // R5: continuous mode toggles on a match
    a_r5_cont_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode_q == MODE_CONT && match && !wr_en)
        |=> (ch_out != $past(ch_out)));

    // R6: a PWM match while counting up drives the active level
    a_r6_pwm_active: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode_q == MODE_PWM && match && !wr_en
         && !(updown_mode && cnt_down)) |=> (ch_out == !pol_q));

    // R9: an interrupt request only follows an enabled match
    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ch_irq |-> $past(en_q && ie_q && match));

    // R12: reserved mode codes hold the output
    a_r12_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode_q > MODE_PWM && !wr_en) |=> $stable(ch_out));

endmodule

bind tmr_cmp_channel tcc_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .en_q        (en_q),
    .pol_q       (pol_q),
    .ie_q        (ie_q),
    .mode_q      (mode_q),
    .match       (match),
    .cnt_down    (cnt_down),
    .updown_mode (updown_mode),
    .state_q     (state_q),
    .ch_out      (ch_out),
    .ch_irq      (ch_irq)
);

// File: tb/test_tmr_cmp_channel.sv
module test_tmr_cmp_channel;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int NBYTES     = CNT_W / 8;
    localparam int ADDR_W     = $clog2(NBYTES + 1);
    localparam int RELOAD     = 20;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cnt_val = '0;
    logic [CNT_W-1:0]  reload_val = CNT_W'(RELOAD);
    logic              cnt_down = 1'b0;
    logic              updown_mode = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              ch_out;
    logic              ch_irq;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    live = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // reference state
    bit             m_en, m_pol, m_ie, m_ue, m_pulse, m_out, m_irq;
    bit [2:0]       m_mode;
    bit [CNT_W-1:0] m_shadow, m_active;

    tmr_cmp_channel #(.CNT_W(CNT_W)) i_tmr_cmp_channel (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .reload_val(reload_val),
        .cnt_down(cnt_down), .updown_mode(updown_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ch_out(ch_out), .ch_irq(ch_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_pol = 0; m_ie = 0; m_ue = 0; m_mode = 0;
            m_pulse = 0; m_out = 0; m_irq = 0; m_shadow = 0; m_active = 0;
        end else begin
            bit hit_match, hit_period, ctrl_w, en_after;
            bit [CNT_W-1:0] old_shadow;
            hit_match  = (cnt_val == m_active);
            hit_period = updown_mode ? (cnt_val == 0 && cnt_down) : (cnt_val == reload_val);
            ctrl_w     = wr_en && wr_addr == 0;
            en_after   = ctrl_w ? wr_data[7] : m_en;
            m_irq      = m_en && m_ie && hit_match;
            if (!m_en) begin
                m_out = (ctrl_w && wr_data[7]) ? wr_data[6] : m_pol;
                m_pulse = 0;
            end else if (m_pulse) begin
                m_out = !m_out;
                m_pulse = 0;
            end else if (m_mode == 3'd0 || m_mode == 3'd1) begin
                if (hit_match) m_out = !m_out;
                m_pulse = (m_mode == 3'd0) && hit_match && en_after;
            end else if (m_mode == 3'd2) begin
                if (updown_mode) begin
                    if (hit_match) m_out = cnt_down ? m_pol : !m_pol;
                end else if (hit_match) m_out = !m_pol;
                else if (cnt_val == reload_val) m_out = m_pol;
            end
            old_shadow = m_shadow;
            for (int b = 0; b < NBYTES; b++) begin
                bit bh;
                bh = wr_en && wr_addr == ADDR_W'(b + 1);
                if (bh) m_shadow[b*8 +: 8] = wr_data;
                if (bh && !m_ue) m_active[b*8 +: 8] = wr_data;
                else if (hit_period) m_active[b*8 +: 8] = old_shadow[b*8 +: 8];
            end
            if (ctrl_w) begin
                m_en = wr_data[7]; m_pol = wr_data[6]; m_ie = wr_data[5];
                m_ue = wr_data[4]; m_mode = wr_data[2:0];
            end
        end
    end

    // counter stimulus and per-cycle comparison
    always @(negedge clk) begin
        cycles++;
        if (live) begin
            chk({cur_tag, " out"}, ch_out, m_en ? m_out : m_pol);
            chk({cur_tag, "/R9 irq"}, ch_irq, m_irq);
        end
        if (!updown_mode) begin
            cnt_down <= 1'b0;
            cnt_val  <= (cnt_val >= reload_val) ? '0 : cnt_val + 1'b1;
        end else if (!cnt_down) begin
            if (cnt_val >= reload_val) begin cnt_down <= 1'b1; cnt_val <= cnt_val - 1'b1; end
            else cnt_val <= cnt_val + 1'b1;
        end else begin
            if (cnt_val == 0) begin cnt_down <= 1'b0; cnt_val <= 1; end
            else cnt_val <= cnt_val - 1'b1;
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        live = 1;
        // R1: reset state
        chk("R1 reset out", ch_out, 1'b0);
        chk("R1 reset irq", ch_irq, 1'b0);
        idle(4);

        // R2: disabled channel follows polarity
        cur_tag = "R2";
        wr(0, 8'h40);
        chk("R2 out=pol 1", ch_out, 1'b1);
        idle(10);
        wr(0, 8'h00);
        chk("R2 out=pol 0", ch_out, 1'b0);
        idle(5);

        // R10/R13: immediate compare, two bytes
        cur_tag = "R10";
        wr(1, 7); wr(2, 0);
        // R3: enable in one-shot with polarity 1 starts high
        cur_tag = "R3";
        wr(0, 8'hE0);
        chk("R3 enable level", ch_out, 1'b1);
        cur_tag = "R4";
        idle(50);
        wr(0, 8'hA0);
        idle(50);

        cur_tag = "R5";
        wr(0, 8'hA1);
        idle(60);

        cur_tag = "R6";
        wr(0, 8'hA2);
        idle(50);
        cur_tag = "R7";
        wr(0, 8'hE2);
        idle(50);
        wr(1, RELOAD);            // compare equal to reload: match wins
        idle(45);
        wr(1, 7);

        cur_tag = "R8";
        updown_mode = 1'b1;
        idle(90);
        wr(0, 8'hA2);
        idle(90);

        // R13: high byte matters, spare address ignored
        cur_tag = "R13";
        wr(2, 1);
        idle(45);
        wr(3, 5);
        idle(45);
        wr(2, 0);

        // R11: buffered update in both counting schemes
        cur_tag = "R11";
        wr(0, 8'hB1);
        idle(7);
        wr(1, 12);
        idle(90);
        updown_mode = 1'b0;
        idle(5);
        wr(1, 3);
        idle(60);

        cur_tag = "R12";
        for (int m = 3; m < 8; m++) begin
            wr(0, 8'hA0 | m);
            idle(25);
        end

        cur_tag = "R2";
        wr(0, 8'h41);
        chk("R2 disable level", ch_out, 1'b1);
        idle(20);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule